// File: doc/BRIEF.md
# Paired-Issue Memory and Register Hazard Gate

This block sits at the issue point of a two-wide in-order core. On each cycle it looks at the instruction in the primary slot (U) and the instruction in the secondary slot (V), and it decides whether the two can leave together. If they cannot, it decides whether V is held for a replay or squashed. U is never stalled by V. The decision covers three hazards:

- V reads a register that U writes.
- The byte ranges of the two memory accesses overlap and at least one of the accesses is a store.
- U stores and V loads. This case is treated as unsafe at any pair of addresses.

Both slots may reach data memory in the same cycle when no hazard is present. No bank check is applied.

The decision is registered. Each slot's request is sampled on a clock edge, and the four decision flags appear at the next edge. A V that is held is expected to be re-presented by the front end as the next U. A V that is squashed is refetched by the front end. Address generation, translation and the memory access itself are outside this block.

Top module: `pair_issue_gate`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all four outputs (`issue_u`, `issue_v`, `hold_v`, `squash_v`) are 0.
- R2: Every output is a function of the inputs sampled at the previous rising clock edge. There is exactly one cycle of latency.
- R3: A valid U slot is always issued (`issue_u`=1), whatever V presents.
- R4: When U is invalid and V is valid, V is promoted to the primary pipe: `issue_u`=1, `issue_v`=0, `hold_v`=0 and `squash_v`=0.
- R5: An invalid V slot never produces `issue_v`, `hold_v` or `squash_v`. When neither slot is valid, all outputs are 0.
- R6: When both slots are valid, U has its store flag set and V has its load flag set, `squash_v`=1 regardless of the two addresses. A squash takes priority over a hold.
- R7: When both slots are valid and U writes a register (`u_wr_en`=1), V is held (`hold_v`=1) if either of its two source indices equals `u_dst`. This is unless R6 applies. The first source is `v_src[RW-1:0]` and the second is `v_src[2*RW-1:RW]`.
- R8: Both slots access memory and at least one of them is a store. If their byte ranges [addr, addr+bytes) overlap, V is held. This includes partial overlap and ranges that cross a 4-byte boundary. Size code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes.
- R9: Two loads with overlapping byte ranges do not conflict and issue together.
- R10: When both slots are valid and no hazard from R6 to R8 is present, `issue_v`=1. A slot with neither its load flag nor its store flag set never takes part in an address clash.
- R11: When both slots are valid, exactly one of `issue_v`, `hold_v` and `squash_v` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| u_valid | input | 1 | Primary slot holds an instruction |
| u_load | input | 1 | Primary slot reads memory |
| u_store | input | 1 | Primary slot writes memory |
| u_wr_en | input | 1 | Primary slot writes its destination register |
| u_dst | input | RW | Primary destination register index |
| u_addr | input | AW | Primary byte address |
| u_size | input | 2 | Primary access size code |
| v_valid | input | 1 | Secondary slot holds an instruction |
| v_load | input | 1 | Secondary slot reads memory |
| v_store | input | 1 | Secondary slot writes memory |
| v_src | input | 2*RW | Secondary source register indices, two fields |
| v_addr | input | AW | Secondary byte address |
| v_size | input | 2 | Secondary access size code |
| issue_u | output | 1 | An instruction leaves on the primary pipe |
| issue_v | output | 1 | V leaves on the secondary pipe |
| hold_v | output | 1 | V is held and replays next cycle as U |
| squash_v | output | 1 | V is squashed because of store-then-load ordering |

## Verification
The hardest cases are the partial overlaps: an unaligned 2-byte or 4-byte access that shares only its first or last byte with the other slot, or that spans a word boundary. Hitting these with directed vectors tends to miss the one-byte edges. The stimulus therefore sweeps both slots over four memory kinds, three sizes and every byte offset across two adjacent words. Each vector is compared with an interval model computed in the bench. Separate passes place a single matching source index in each source field, and then switch off the register write, to reach the dependency cases.

// File: rtl/pig_pkg.sv
package pig_pkg;

  // Decision classes for a valid pair
  typedef enum logic [1:0] {
    DEC_PAIR   = 2'd0,
    DEC_HOLD   = 2'd1,
    DEC_SQUASH = 2'd2,
    DEC_SOLO   = 2'd3
  } pair_dec_e;

  localparam int SIZE_CODE_W = 2;
  localparam int MAX_BYTES   = 4;

  // Size code to byte count: 0->1, 1->2, 2 and 3 -> 4
  function automatic logic [2:0] code_to_bytes(input logic [SIZE_CODE_W-1:0] code);
    case (code)
      2'd0:    code_to_bytes = 3'd1;
      2'd1:    code_to_bytes = 3'd2;
      default: code_to_bytes = 3'(MAX_BYTES);
    endcase
  endfunction

endpackage

// File: rtl/byte_range_overlap.sv
module byte_range_overlap
  import pig_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]          a_addr,
  input  logic [SIZE_CODE_W-1:0] a_size,
  input  logic [AW-1:0]          b_addr,
  input  logic [SIZE_CODE_W-1:0] b_size,
  output logic                   hit
);
  localparam int EW = AW + 1;

  logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = {1'b0, a_addr};
    b_lo = {1'b0, b_addr};
    a_hi = a_lo + EW'(code_to_bytes(a_size));
    b_hi = b_lo + EW'(code_to_bytes(b_size));
    hit  = (a_lo < b_hi) && (b_lo < a_hi);
  end
endmodule

// File: rtl/src_dest_match.sv
module src_dest_match #(
  parameter int RW   = 5,
  parameter int NSRC = 2
) (
  input  logic               wr_en,
  input  logic [RW-1:0]      dst,
  input  logic [NSRC*RW-1:0] srcs,
  output logic               dep
);
  logic [NSRC-1:0] eq;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign eq[g] = (srcs[g*RW +: RW] == dst);
  end

  assign dep = wr_en && (|eq);
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate
  import pig_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   u_valid,
  input  logic                   u_load,
  input  logic                   u_store,
  input  logic                   u_wr_en,
  input  logic [RW-1:0]          u_dst,
  input  logic [AW-1:0]          u_addr,
  input  logic [SIZE_CODE_W-1:0] u_size,
  input  logic                   v_valid,
  input  logic                   v_load,
  input  logic                   v_store,
  input  logic [2*RW-1:0]        v_src,
  input  logic [AW-1:0]          v_addr,
  input  logic [SIZE_CODE_W-1:0] v_size,
  output logic                   issue_u,
  output logic                   issue_v,
  output logic                   hold_v,
  output logic                   squash_v
);
  localparam int NSRC = 2;

  logic both, u_mem, v_mem, any_st;
  logic ovl_hit, reg_dep, clash;
  pair_dec_e dec;

  byte_range_overlap #(.AW(AW)) u_ovl (
    .a_addr(u_addr), .a_size(u_size),
    .b_addr(v_addr), .b_size(v_size),
    .hit(ovl_hit)
  );

  src_dest_match #(.RW(RW), .NSRC(NSRC)) u_dep (
    .wr_en(u_wr_en), .dst(u_dst), .srcs(v_src), .dep(reg_dep)
  );

  always_comb begin
    both   = u_valid && v_valid;
    u_mem  = u_load || u_store;
    v_mem  = v_load || v_store;
    any_st = u_store || v_store;
    clash  = u_mem && v_mem && any_st && ovl_hit;
    if (!both)                   dec = DEC_SOLO;
    else if (u_store && v_load)  dec = DEC_SQUASH;
    else if (clash || reg_dep)   dec = DEC_HOLD;
    else                         dec = DEC_PAIR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_u  <= 1'b0;
      issue_v  <= 1'b0;
      hold_v   <= 1'b0;
      squash_v <= 1'b0;
    end else begin
      issue_u  <= u_valid || v_valid;
      issue_v  <= (dec == DEC_PAIR);
      hold_v   <= (dec == DEC_HOLD);
      squash_v <= (dec == DEC_SQUASH);
    end
  end
endmodule

// File: rtl/pair_issue_gate_chk.sv
module pair_issue_gate_chk #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input logic clk,
  input logic rst,
  input logic u_valid,
  input logic u_store,
  input logic v_valid,
  input logic v_load,
  input logic issue_u,
  input logic issue_v,
  input logic hold_v,
  input logic squash_v
);
  logic prev_ok;

  always_ff @(posedge clk) begin
    if (rst) prev_ok <= 1'b0;
    else     prev_ok <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !(issue_u || issue_v || hold_v || squash_v));

  a_r3_u_priority: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && $past(u_valid)) |-> issue_u);

  a_r5_no_v_decision: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && !$past(v_valid)) |-> !(issue_v || hold_v || squash_v));

  a_r6_store_load_squash: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && $past(u_valid && v_valid && u_store && v_load)) |-> squash_v);

  a_r11_one_v_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({issue_v, hold_v, squash_v}));

  a_r11_pair_decided: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && $past(u_valid && v_valid)) |-> (issue_v || hold_v || squash_v));

  a_r10_v_needs_u: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> issue_u);
endmodule

bind pair_issue_gate pair_issue_gate_chk #(.AW(AW), .RW(RW)) u_chk (.*);

// File: tb/pair_issue_gate_tb.sv
module pair_issue_gate_tb;
  localparam int AW = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst;
  logic u_valid, u_load, u_store, u_wr_en;
  logic [RW-1:0] u_dst;
  logic [AW-1:0] u_addr;
  logic [1:0] u_size;
  logic v_valid, v_load, v_store;
  logic [2*RW-1:0] v_src;
  logic [AW-1:0] v_addr;
  logic [1:0] v_size;
  logic issue_u, issue_v, hold_v, squash_v;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pair_issue_gate #(.AW(AW), .RW(RW)) u_dut (.*);

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic compare(input string tag, input logic eu, ev, eh, es);
    checks++;
    if ({issue_u, issue_v, hold_v, squash_v} !== {eu, ev, eh, es}) begin
      errors++;
      $display("FAIL %s: got u/v/hold/squash=%b%b%b%b expected %b%b%b%b (ua=%0h us=%0d va=%0h vs=%0d)",
               tag, issue_u, issue_v, hold_v, squash_v, eu, ev, eh, es,
               u_addr, u_size, v_addr, v_size);
    end
  endtask

  // Drive at a falling edge; the decision appears after the next rising edge.
  task automatic step_and_check(input string tag, input logic eu, ev, eh, es);
    @(negedge clk);
    compare(tag, eu, ev, eh, es);
  endtask

  task automatic idle();
    u_valid = 0; u_load = 0; u_store = 0; u_wr_en = 0; u_dst = '0;
    u_addr = '0; u_size = '0;
    v_valid = 0; v_load = 0; v_store = 0; v_src = '0;
    v_addr = '0; v_size = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    compare("R1 in reset", 0, 0, 0, 0);
    // Apply a hazardous pair while reset is still high
    u_valid = 1; u_store = 1; v_valid = 1; v_load = 1;
    @(negedge clk);
    compare("R1 reset holds outputs low", 0, 0, 0, 0);
    rst = 0;
    idle();
    step_and_check("R1 first cycle after reset, idle", 0, 0, 0, 0);

    // R2: one-cycle latency. Present a squash pair, then idle, check timing.
    u_valid = 1; u_store = 1; v_valid = 1; v_load = 1;
    @(posedge clk); #1;
    compare("R2 output follows the sampled pair", 1, 0, 0, 1);
    idle();
    @(negedge clk);
    compare("R2 still shows earlier decision before next edge", 1, 0, 0, 1);
    step_and_check("R2 idle decision one cycle later", 0, 0, 0, 0);

    // Exhaustive memory sweep: kinds 0 none, 1 load, 2 store, 3 load+store
    u_dst = 5'd1; v_src = {5'd3, 5'd2}; u_wr_en = 1;
    for (int uk = 0; uk < 4; uk++)
      for (int vk = 0; vk < 4; vk++)
        for (int us = 0; us < 3; us++)
          for (int vs = 0; vs < 3; vs++)
            for (int uo = 0; uo < 8; uo++)
              for (int vo = 0; vo < 8; vo++) begin
                logic ul, ust, vl, vst, ovl, sq, hd;
                string tag;
                ul = uk[0]; ust = uk[1]; vl = vk[0]; vst = vk[1];
                u_valid = 1; v_valid = 1;
                u_load = ul; u_store = ust; v_load = vl; v_store = vst;
                u_size = 2'(us); v_size = 2'(vs);
                u_addr = 32'h0000_0100 + 32'(uo);
                v_addr = 32'h0000_0100 + 32'(vo);
                ovl = (uo < vo + nbytes(2'(vs))) && (vo < uo + nbytes(2'(us)));
                sq  = ust && vl;
                hd  = !sq && (ul || ust) && (vl || vst) && (ust || vst) && ovl;
                if (sq)                    tag = "R6 store then load";
                else if (hd)               tag = "R8 byte overlap with store";
                else if (ul && vl && ovl)  tag = "R9 overlapping loads";
                else                       tag = "R10 no hazard";
                step_and_check(tag, 1, !(sq || hd), hd, sq);
              end

    // Size code 3 counts as four bytes (R8)
    u_valid = 1; v_valid = 1; u_load = 0; u_store = 1; v_load = 0; v_store = 1;
    u_size = 2'd3; v_size = 2'd0; u_addr = 32'h200; v_addr = 32'h203;
    step_and_check("R8 size code 3 reaches fourth byte", 1, 0, 1, 0);
    v_addr = 32'h204;
    step_and_check("R8 size code 3 stops after fourth byte", 1, 1, 0, 0);

    // Register dependency (R7), no memory access
    u_load = 0; u_store = 0; v_load = 0; v_store = 0;
    u_wr_en = 1; u_dst = 5'd9;
    v_src = {5'd4, 5'd9};
    step_and_check("R7 first source matches", 1, 0, 1, 0);
    v_src = {5'd9, 5'd4};
    step_and_check("R7 second source matches", 1, 0, 1, 0);
    v_src = {5'd4, 5'd5};
    step_and_check("R7 no source matches", 1, 1, 0, 0);
    v_src = {5'd9, 5'd9}; u_wr_en = 0;
    step_and_check("R7 no register write, no hold", 1, 1, 0, 0);
    u_wr_en = 1; u_store = 1; v_load = 1; u_addr = 32'h0; v_addr = 32'h80;
    step_and_check("R6 squash wins over register hold", 1, 0, 0, 1);
    u_store = 0; v_load = 0;

    // Invalid slots (R4, R5)
    u_valid = 0; v_valid = 1; u_store = 1; v_load = 1;
    step_and_check("R4 V promoted when U invalid", 1, 0, 0, 0);
    u_valid = 1; v_valid = 0;
    step_and_check("R5 invalid V, U store", 1, 0, 0, 0);
    u_valid = 0;
    step_and_check("R5 both invalid", 0, 0, 0, 0);
    u_valid = 1; v_valid = 1; u_store = 0; v_load = 0; v_src = '0;
    step_and_check("R3 U issued in plain pair", 1, 1, 0, 0);

    // Reset mid-run returns outputs low (R1)
    rst = 1;
    step_and_check("R1 reset asserted mid-run", 0, 0, 0, 0);
    rst = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule